// File: doc/BRIEF.md
# Clock Source and CPU Divider Controller

This block decides where a chip's fast clock comes from and how often the CPU and the peripherals may act on it. Software writes a few small control registers over a simple write/read port. One register picks between the on-chip oscillator path and an external clock pin. A second register starts or halts the external input. A third couples the main clock and the peripheral clock to the high-speed source or leaves both on the internal oscillator. A fourth chooses a power-of-two CPU ratio.

The block does not gate real clocks. Every clock is modelled as a one-cycle enable strobe on the reference clock. `periph_en` marks each cycle in which the main clock ticks. `cpu_en` marks one main tick out of every N, where N is the selected ratio. Writes that would break a running external clock are refused, and so are illegal ratio codes. Each refusal leaves a sticky flag, which stays set until reset. A status word gathers the live source, the run state, the active ratio and both flags.

Top module: `ccu_clk_ctrl`

## Requirements
- R1: After reset the status word (address 4) reads 0x08, the stop register (address 1) reads 0x01 and the divide register (address 3) reads 0x01. The CPU strobe has a period of 2, and `periph_en` is high on every cycle.
- R2: The source register (address 3'd0) has bit 0 as the external-clock bit and bit 1 as the oscillator-select bit. External input mode (`src_ext`, status bit 0) is entered only when both bits are 1. With any other value both pins stay in port mode.
- R3: The stop register bit 0 controls the external input: 1 halts it and 0 lets it run. `ext_run` (status bit 1) is high only when external mode is on and the stop bit is 0. If the high-speed clock is the main clock and it is external and halted, neither `periph_en` nor `cpu_en` pulses.
- R4: While `ext_run` is high, a write to the source register with a value different from the stored one is discarded and sets the sticky `err_lock` (status bit 6).
- R5: The main-select register (address 2) has bit 0 as the high-speed-select bit and bit 1 as the mode bit. When both are 1, the high-speed clock drives both the main clock and the peripheral clock (`main_hs`, status bit 2). With any other value both clocks run from the always-ticking internal oscillator. `periph_en` follows the main tick one cycle later.
- R6: The divide register bits 2:0 hold the ratio code: 0, 1, 2, 3 and 4 give /1, /2, /4, /8 and /16 of the main tick. With /1, `cpu_en` stays high on every main tick. `cpu_en` is never high when `periph_en` is low.
- R7: A divide write is discarded and sets the sticky `err_div` (status bit 7) in two cases: the code is 5, 6 or 7, or bit 3 (the CPU-source bit) is 1. The CPU may only run from the main clock. The previous ratio stays in force.
- R8: A new ratio takes effect only at the end of the division period in progress. The gap between the last pulse at the old ratio and the next pulse equals the old period.
- R9: A read sets `rd_valid` and `rdata` one cycle after `rd_en`. Status bits 5:3 give the active ratio code. Addresses 5 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data strobe, one cycle after rd_en |
| cpu_en | output | 1 | CPU clock enable strobe |
| periph_en | output | 1 | Main and peripheral clock enable strobe |
| src_ext | output | 1 | External clock input mode is selected |
| ext_run | output | 1 | External clock input is running |
| main_hs | output | 1 | High-speed clock drives main and peripheral clocks |
| err_lock | output | 1 | Sticky: locked source write refused |
| err_div | output | 1 | Sticky: illegal divide write refused |

## Verification
The bench uses the default parameters: a 3-bit ratio code, ratios up to /16 and a reset ratio of /2. With these values every legal ratio can be measured from one pulse to the next. The longest period, 16 cycles, leaves enough room to write a new ratio in the middle of a period and show that the switch waits for the boundary. Because code 4 is the top legal code, codes 5 to 7 are also available to test the rejection path.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
  localparam int REG_AW = 3;
  localparam int REG_DW = 8;

  localparam logic [REG_AW-1:0] A_SRC  = 3'd0;
  localparam logic [REG_AW-1:0] A_STOP = 3'd1;
  localparam logic [REG_AW-1:0] A_MAIN = 3'd2;
  localparam logic [REG_AW-1:0] A_DIV  = 3'd3;
  localparam logic [REG_AW-1:0] A_STAT = 3'd4;
endpackage

// File: rtl/ccu_regs.sv
module ccu_regs
  import ccu_pkg::*;
#(
  parameter int DIV_W    = 3,
  parameter int MAX_LOG2 = 4,
  parameter int RST_CODE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  output logic              ext_bit,
  output logic              osc_bit,
  output logic              stop,
  output logic              hs_sel,
  output logic              mode_bit,
  output logic [DIV_W-1:0]  pend_code,
  output logic              ext_mode,
  output logic              ext_run,
  output logic              err_lock,
  output logic              err_div
);
  logic unused_wdata;
  logic src_changes;
  logic div_legal;

  assign unused_wdata = ^wdata;
  assign ext_mode     = ext_bit & osc_bit;
  assign ext_run      = ext_mode & ~stop;
  assign src_changes  = (wdata[1:0] != {osc_bit, ext_bit});
  assign div_legal    = ~wdata[DIV_W] &&
                        (int'(wdata[DIV_W-1:0]) <= MAX_LOG2);

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_bit   <= 1'b0;
      osc_bit   <= 1'b0;
      stop      <= 1'b1;
      hs_sel    <= 1'b0;
      mode_bit  <= 1'b0;
      pend_code <= DIV_W'(RST_CODE);
      err_lock  <= 1'b0;
      err_div   <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        A_SRC: begin
          if (ext_run && src_changes) begin
            err_lock <= 1'b1;
          end else begin
            ext_bit <= wdata[0];
            osc_bit <= wdata[1];
          end
        end
        A_STOP: stop <= wdata[0];
        A_MAIN: begin
          hs_sel   <= wdata[0];
          mode_bit <= wdata[1];
        end
        A_DIV: begin
          if (div_legal) pend_code <= wdata[DIV_W-1:0];
          else           err_div   <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ccu_src_sel.sv
module ccu_src_sel (
  input  logic clk,
  input  logic rst,
  input  logic ext_mode,
  input  logic ext_run,
  input  logic hs_sel,
  input  logic mode_bit,
  output logic main_hs,
  output logic main_tick,
  output logic periph_en
);
  logic hs_tick;

  assign main_hs   = hs_sel & mode_bit;
  assign hs_tick   = ext_mode ? ext_run : 1'b1;
  assign main_tick = main_hs ? hs_tick : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) periph_en <= 1'b0;
    else     periph_en <= main_tick;
  end
endmodule

// File: rtl/ccu_cpu_div.sv
module ccu_cpu_div #(
  parameter int DIV_W    = 3,
  parameter int MAX_LOG2 = 4,
  parameter int RST_CODE = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [DIV_W-1:0] pend_code,
  output logic [DIV_W-1:0] active_code,
  output logic             cpu_en
);
  localparam int CNT_W = (MAX_LOG2 > 0) ? MAX_LOG2 : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   lim;
  logic             term;

  assign lim  = ((CNT_W+1)'(1) << active_code) - (CNT_W+1)'(1);
  assign term = ({1'b0, cnt_q} == lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q       <= '0;
      active_code <= DIV_W'(RST_CODE);
      cpu_en      <= 1'b0;
    end else begin
      cpu_en <= tick && term;
      if (tick) begin
        if (term) begin
          cnt_q       <= '0;
          active_code <= pend_code;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ccu_clk_ctrl.sv
module ccu_clk_ctrl
  import ccu_pkg::*;
#(
  parameter int DIV_W    = 3,
  parameter int MAX_LOG2 = 4,
  parameter int RST_CODE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  output logic [REG_DW-1:0] rdata,
  output logic              rd_valid,
  output logic              cpu_en,
  output logic              periph_en,
  output logic              src_ext,
  output logic              ext_run,
  output logic              main_hs,
  output logic              err_lock,
  output logic              err_div
);
  logic             ext_bit, osc_bit, stop, hs_sel, mode_bit, main_tick;
  logic [DIV_W-1:0] pend_code, active_code;
  logic [REG_DW-1:0] rd_mux;

  ccu_regs #(.DIV_W(DIV_W), .MAX_LOG2(MAX_LOG2), .RST_CODE(RST_CODE)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ext_bit(ext_bit), .osc_bit(osc_bit), .stop(stop), .hs_sel(hs_sel),
    .mode_bit(mode_bit), .pend_code(pend_code), .ext_mode(src_ext),
    .ext_run(ext_run), .err_lock(err_lock), .err_div(err_div)
  );

  ccu_src_sel u_src (
    .clk(clk), .rst(rst), .ext_mode(src_ext), .ext_run(ext_run),
    .hs_sel(hs_sel), .mode_bit(mode_bit), .main_hs(main_hs),
    .main_tick(main_tick), .periph_en(periph_en)
  );

  ccu_cpu_div #(.DIV_W(DIV_W), .MAX_LOG2(MAX_LOG2), .RST_CODE(RST_CODE)) u_div (
    .clk(clk), .rst(rst), .tick(main_tick), .pend_code(pend_code),
    .active_code(active_code), .cpu_en(cpu_en)
  );

  always_comb begin
    case (addr)
      A_SRC:   rd_mux = REG_DW'({osc_bit, ext_bit});
      A_STOP:  rd_mux = REG_DW'(stop);
      A_MAIN:  rd_mux = REG_DW'({mode_bit, hs_sel});
      A_DIV:   rd_mux = REG_DW'(pend_code);
      A_STAT:  rd_mux = REG_DW'({err_div, err_lock, active_code,
                                 main_hs, ext_run, src_ext});
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rdata    <= '0;
    end else begin
      rd_valid <= rd_en;
      rdata    <= rd_en ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/ccu_clk_ctrl_chk.sv
module ccu_clk_ctrl_chk #(
  parameter int DIV_W    = 3,
  parameter int MAX_LOG2 = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [2:0] addr,
  input logic [7:0] wdata,
  input logic       cpu_en,
  input logic       periph_en,
  input logic       src_ext,
  input logic       ext_run,
  input logic       main_hs,
  input logic       err_lock,
  input logic       err_div
);
  logic bad_div;
  assign bad_div = wdata[DIV_W] || (int'(wdata[DIV_W-1:0]) > MAX_LOG2);

  p_ext_mode_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    (ext_run && wr_en && addr == 3'd0) |=> $stable(src_ext));

  p_lock_flag_r4: assert property (@(posedge clk) disable iff (rst)
    (ext_run && wr_en && addr == 3'd0 && wdata[1:0] != 2'b11) |=> err_lock);

  p_lock_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    err_lock |=> err_lock);

  p_halted_no_tick_r3: assert property (@(posedge clk) disable iff (rst)
    (main_hs && src_ext && !ext_run) |=> !periph_en);

  p_internal_ticks_r5: assert property (@(posedge clk) disable iff (rst)
    !main_hs |=> periph_en);

  p_cpu_within_main_r6: assert property (@(posedge clk) disable iff (rst)
    cpu_en |-> periph_en);

  p_div_reject_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd3 && bad_div) |=> err_div);

  p_div_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    err_div |=> err_div);
endmodule

bind ccu_clk_ctrl ccu_clk_ctrl_chk #(.DIV_W(DIV_W), .MAX_LOG2(MAX_LOG2)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .cpu_en(cpu_en), .periph_en(periph_en), .src_ext(src_ext),
  .ext_run(ext_run), .main_hs(main_hs), .err_lock(err_lock), .err_div(err_div)
);

// File: tb/tb_ccu_clk_ctrl.sv
module tb_ccu_clk_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rd_valid, cpu_en, periph_en, src_ext, ext_run, main_hs, err_lock, err_div;

  ccu_clk_ctrl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rd_valid(rd_valid), .cpu_en(cpu_en), .periph_en(periph_en),
    .src_ext(src_ext), .ext_run(ext_run), .main_hs(main_hs),
    .err_lock(err_lock), .err_div(err_div)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_run = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  // Monitor: pops expected read data as rd_valid appears (R9)
  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected read", int'(rdata), -1);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rdata == e, t, int'(rdata), int'(e));
      end
    end
  end

  task automatic measure(output int p);
    int c;
    c = 0;
    while (!cpu_en && c < 200) begin @(negedge clk); c++; end
    c = 0;
    do begin @(negedge clk); c++; end while (!cpu_en && c < 200);
    p = c;
  endtask

  task automatic count_high(input int n, output int h, output int hc);
    h = 0; hc = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (periph_en) h++;
      if (cpu_en) hc++;
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      summary();
    end
  end

  initial begin
    int p, h, hc, c;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(3'd4, 8'h08, "R1 status after reset");
    rd(3'd1, 8'h01, "R1 stop after reset");
    rd(3'd3, 8'h01, "R1 divide after reset");
    check(periph_en == 1'b1, "R1 periph_en after reset", periph_en, 1);
    measure(p);
    check(p == 2, "R1 reset period", p, 2);

    // R2 external mode needs both bits
    wr(3'd0, 8'h01); check(src_ext == 1'b0, "R2 ext bit only", src_ext, 0);
    rd(3'd0, 8'h01, "R2 source readback");
    wr(3'd0, 8'h02); check(src_ext == 1'b0, "R2 osc bit only", src_ext, 0);
    wr(3'd0, 8'h03); check(src_ext == 1'b1, "R2 both bits", src_ext, 1);
    rd(3'd4, 8'h09, "R2 status ext mode stopped");
    wr(3'd0, 8'h00);
    rd(3'd5, 8'h00, "R9 unused address");

    // R6 every legal ratio
    for (int k = 0; k <= 4; k++) begin
      wr(3'd3, 8'(k));
      measure(p);
      measure(p);
      check(p == (1 << k), $sformatf("R6 period code %0d", k), p, 1 << k);
      if (k == 0) begin
        count_high(8, h, hc);
        check(hc == 8, "R6 ratio 1 continuous", hc, 8);
      end
    end
    rd(3'd4, 8'h20, "R9 status active code 4");

    // R8 switch waits for the period boundary (/16 -> /1)
    c = 0;
    while (!cpu_en && c < 200) begin @(negedge clk); c++; end
    wr(3'd3, 8'h00);
    c = 1;
    while (!cpu_en && c < 200) begin @(negedge clk); c++; end
    check(c == 16, "R8 old period kept", c, 16);
    measure(p);
    check(p == 1, "R8 new ratio after boundary", p, 1);

    // R7 prohibited codes rejected
    wr(3'd3, 8'h02);
    wr(3'd3, 8'h05);
    check(err_div == 1'b1, "R7 err_div on code 5", err_div, 1);
    rd(3'd3, 8'h02, "R7 divide kept after code 5");
    wr(3'd3, 8'h08);
    rd(3'd3, 8'h02, "R7 divide kept after cpu-source bit");
    measure(p); measure(p);
    check(p == 4, "R7 period unchanged", p, 4);
    rd(3'd4, 8'h90, "R7 status error flag");

    // R3 / R5 halted external high-speed source
    wr(3'd2, 8'h03);
    wr(3'd0, 8'h03);
    @(negedge clk);
    check(main_hs == 1'b1, "R5 main_hs set", main_hs, 1);
    count_high(6, h, hc);
    check(h == 0, "R3 no periph tick while halted", h, 0);
    check(hc == 0, "R3 no cpu tick while halted", hc, 0);
    wr(3'd1, 8'h00);
    @(negedge clk);
    check(ext_run == 1'b1, "R3 ext_run after start", ext_run, 1);
    count_high(6, h, hc);
    check(h == 6, "R3 periph ticks when running", h, 6);

    // R4 locked source write
    check(err_lock == 1'b0, "R4 err_lock clear before", err_lock, 0);
    wr(3'd0, 8'h00);
    check(err_lock == 1'b1, "R4 err_lock set", err_lock, 1);
    check(src_ext == 1'b1, "R4 ext mode kept", src_ext, 1);
    rd(3'd0, 8'h03, "R4 source readback kept");
    rd(3'd4, 8'hD7, "R4 status running locked");

    // R5 internal oscillator when select is incomplete
    wr(3'd2, 8'h01);
    wr(3'd1, 8'h01);
    @(negedge clk);
    check(main_hs == 1'b0, "R5 hs bit only", main_hs, 0);
    count_high(6, h, hc);
    check(h == 6, "R5 internal ticks with ext halted", h, 6);
    wr(3'd2, 8'h02);
    check(main_hs == 1'b0, "R5 mode bit only", main_hs, 0);
    wr(3'd0, 8'h00);
    check(src_ext == 1'b0, "R4 write allowed when stopped", src_ext, 0);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R9 all reads answered", exp_q.size(), 0);
    done = 1;
    summary();
  end
endmodule